// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirection Unit

This unit decides where an interrupt request is sent while a task runs in virtual-8086 mode. A request carries an 8-bit vector, a flag that marks it as a hardware or a software interrupt, the current mode and extension-enable flags, the 2-bit I/O privilege level and the base address of the task's I/O permission bitmap. Some software interrupts need a per-vector check. For those, the unit reads one byte of a 256-bit redirection bitmap. The bitmap occupies the 32 bytes directly below the I/O permission bitmap base, and the unit reads it through a simple read port that waits for data.

The unit reports one of three results. The first sends the interrupt through the virtual-8086 vector table at the bottom of the task address space, and gives the table entry address. The second sends it through the protected-mode descriptor table. The third is a general-protection fault with a zero error code. When no bitmap lookup is needed, the answer arrives one cycle after the request. A new request is accepted only while the unit is idle, and each answer comes with a one-cycle result strobe.

Top module: `swint_redirect`

## Requirements
- R1: After a synchronous reset, resValid and memRdEn are 0 and reqReady is 1.
- R2: A software request with v86Mode=1 and extEnable=1 raises memRdEn from the cycle after acceptance. The read address is permBase - 32 + reqVector[7:3], and memRdEn and the address stay constant until a cycle in which memRdValid is 1.
- R3: The bit tested is bit reqVector[2:0] of memRdData. When that bit is 0, resCode is 2'b01 (virtual-8086 table) and resTableAddr is reqVector*4 with all upper bits zero. For any other code, resTableAddr is 0.
- R4: When the tested bit is 1 and the privilege level is 3, resCode is 2'b10 (protected-mode descriptor table).
- R5: When the tested bit is 1 and the privilege level is below 3, resCode is 2'b11 (general-protection fault) and resErrCode is 0.
- R6: A hardware request (reqIsHw=1) gives resCode 2'b10 without a memory read, with resValid high in the cycle after acceptance.
- R7: A software request in virtual-8086 mode with extEnable=0 does not read memory and answers in the cycle after acceptance. The result is 2'b10 when the privilege level is 3 and 2'b11 otherwise.
- R8: A request with v86Mode=0 gives resCode 2'b10 without a memory read, in the cycle after acceptance.
- R9: resValid is high for one cycle per accepted request. reqReady is low while a lookup is in progress, and requests offered during that time are ignored.
- R10: A request offered in the same cycle as a result strobe is accepted.
- R11: A synchronous reset during a lookup abandons it and produces no result.
- R12: memRdValid while no read is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle, request will be taken |
| reqVector | input | 8 | Interrupt vector |
| reqIsHw | input | 1 | 1 for a hardware interrupt |
| v86Mode | input | 1 | Task runs in virtual-8086 mode |
| extEnable | input | 1 | Virtual-mode extensions enabled |
| ioPriv | input | 2 | I/O privilege level |
| permBase | input | ADDR_W | I/O permission bitmap base address |
| memRdEn | output | 1 | Read request, held until data returns |
| memRdAddr | output | ADDR_W | Byte address of the bitmap byte |
| memRdData | input | 8 | Read data |
| memRdValid | input | 1 | Read data valid |
| resValid | output | 1 | Result strobe |
| resCode | output | 2 | 01 vector table, 10 descriptor table, 11 fault |
| resTableAddr | output | ADDR_W | Vector table entry address |
| resErrCode | output | ERR_W | Fault error code |

## Verification
Two events can fall in the same cycle: a result strobe and the acceptance of the next request. The unit is idle again while it presents a result, so it can take a new request at that moment. The bench offers a lookup request exactly while the strobe of a previous direct answer is high. It then checks that the strobe still drops after one cycle, that the read starts at the new address, and that the second result belongs to the second request and not to the first.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'b00,
    OUT_V86  = 2'b01,
    OUT_IDT  = 2'b10,
    OUT_GPF  = 2'b11
  } outcome_e;

  typedef struct packed {
    logic capture;
    logic startRead;
    logic finishDirect;
    logic finishLookup;
  } ctlStrobes_t;
endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        needLookup,
  input  logic        memRdValid,
  output ctlStrobes_t strobes,
  output logic        reqReady,
  output logic        memRdEn
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state;

  always_comb begin
    reqReady              = (state == ST_IDLE);
    memRdEn               = (state == ST_WAIT);
    strobes.capture       = reqValid && reqReady;
    strobes.startRead     = strobes.capture && needLookup;
    strobes.finishDirect  = strobes.capture && !needLookup;
    strobes.finishLookup  = memRdEn && memRdValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (strobes.startRead) begin
      state <= ST_WAIT;
    end else if (strobes.finishLookup) begin
      state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/swr_datapath.sv
module swr_datapath
  import swr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              reqIsHw,
  input  logic              v86Mode,
  input  logic              extEnable,
  input  logic [1:0]        ioPriv,
  input  logic [ADDR_W-1:0] permBase,
  input  logic [7:0]        memRdData,
  output logic              needLookup,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              resValid,
  output logic [1:0]        resCode,
  output logic [ADDR_W-1:0] resTableAddr,
  output logic [ERR_W-1:0]  resErrCode
);
  localparam int BIT_SEL_W    = 3;
  localparam int BITMAP_BYTES = (1 << VEC_W) / 8;
  localparam int ENTRY_SHIFT  = 2;

  logic [VEC_W-1:0]  vecQ;
  logic [1:0]        ioPrivQ;
  logic [ADDR_W-1:0] addrQ;
  outcome_e          directCode;
  outcome_e          lookupCode;
  logic              bitSet;

  always_comb begin
    needLookup = v86Mode && extEnable && !reqIsHw;
    if (!v86Mode || reqIsHw) begin
      directCode = OUT_IDT;
    end else begin
      directCode = (ioPriv == 2'd3) ? OUT_IDT : OUT_GPF;
    end
    bitSet = memRdData[vecQ[BIT_SEL_W-1:0]];
    if (!bitSet) begin
      lookupCode = OUT_V86;
    end else begin
      lookupCode = (ioPrivQ == 2'd3) ? OUT_IDT : OUT_GPF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vecQ    <= '0;
      ioPrivQ <= '0;
      addrQ   <= '0;
    end else if (strobes.capture) begin
      vecQ    <= reqVector;
      ioPrivQ <= ioPriv;
      addrQ   <= permBase - ADDR_W'(BITMAP_BYTES)
               + ADDR_W'(reqVector[VEC_W-1:BIT_SEL_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid     <= 1'b0;
      resCode      <= OUT_NONE;
      resTableAddr <= '0;
    end else begin
      resValid <= strobes.finishDirect || strobes.finishLookup;
      if (strobes.finishDirect) begin
        resCode      <= directCode;
        resTableAddr <= '0;
      end else if (strobes.finishLookup) begin
        resCode      <= lookupCode;
        resTableAddr <= (lookupCode == OUT_V86)
                      ? ADDR_W'({vecQ, {ENTRY_SHIFT{1'b0}}}) : '0;
      end
    end
  end

  assign memRdAddr  = addrQ;
  assign resErrCode = '0;
endmodule

// File: rtl/swint_redirect.sv
module swint_redirect
  import swr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [7:0]        reqVector,
  input  logic              reqIsHw,
  input  logic              v86Mode,
  input  logic              extEnable,
  input  logic [1:0]        ioPriv,
  input  logic [ADDR_W-1:0] permBase,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  input  logic              memRdValid,
  output logic              resValid,
  output logic [1:0]        resCode,
  output logic [ADDR_W-1:0] resTableAddr,
  output logic [ERR_W-1:0]  resErrCode
);
  ctlStrobes_t strobes;
  logic        needLookup;

  swr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .needLookup (needLookup),
    .memRdValid (memRdValid),
    .strobes    (strobes),
    .reqReady   (reqReady),
    .memRdEn    (memRdEn)
  );

  swr_datapath #(.ADDR_W(ADDR_W), .ERR_W(ERR_W), .VEC_W(8)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .reqVector    (reqVector),
    .reqIsHw      (reqIsHw),
    .v86Mode      (v86Mode),
    .extEnable    (extEnable),
    .ioPriv       (ioPriv),
    .permBase     (permBase),
    .memRdData    (memRdData),
    .needLookup   (needLookup),
    .memRdAddr    (memRdAddr),
    .resValid     (resValid),
    .resCode      (resCode),
    .resTableAddr (resTableAddr),
    .resErrCode   (resErrCode)
  );
endmodule

// File: rtl/swint_redirect_chk.sv
module swint_redirect_chk #(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqIsHw,
  input logic              v86Mode,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdValid,
  input logic              resValid,
  input logic [1:0]        resCode,
  input logic [ADDR_W-1:0] resTableAddr,
  input logic [ERR_W-1:0]  resErrCode
);
  a_r2_read_held: assert property (@(posedge clk) disable iff (rst)
    (memRdEn && !memRdValid) |=> (memRdEn && $stable(memRdAddr)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> !reqReady);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (resValid && !(reqValid && reqReady)) |=> !resValid);

  a_r5_zero_error: assert property (@(posedge clk) disable iff (rst)
    (resValid && resCode == 2'b11) |-> (resErrCode == '0));

  a_r3_addr_only_v86: assert property (@(posedge clk) disable iff (rst)
    (resValid && resCode != 2'b01) |-> (resTableAddr == '0));

  a_r6_hw_direct: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqIsHw) |=> (!memRdEn && resValid && resCode == 2'b10));

  a_r8_native_direct: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !v86Mode) |=> (!memRdEn && resValid && resCode == 2'b10));

  a_r12_result_has_cause: assert property (@(posedge clk) disable iff (rst)
    resValid |-> ($past(reqValid && reqReady) || $past(memRdEn && memRdValid)));
endmodule

bind swint_redirect swint_redirect_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqIsHw      (reqIsHw),
  .v86Mode      (v86Mode),
  .memRdEn      (memRdEn),
  .memRdAddr    (memRdAddr),
  .memRdValid   (memRdValid),
  .resValid     (resValid),
  .resCode      (resCode),
  .resTableAddr (resTableAddr),
  .resErrCode   (resErrCode)
);

// File: tb/swint_redirect_bench.sv
module swint_redirect_bench;
  localparam int AW = 32;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [7:0]    reqVector = '0;
  logic          reqIsHw = 1'b0;
  logic          v86Mode = 1'b0;
  logic          extEnable = 1'b0;
  logic [1:0]    ioPriv = '0;
  logic [AW-1:0] permBase = '0;
  logic          memRdEn;
  logic [AW-1:0] memRdAddr;
  logic [7:0]    memRdData = '0;
  logic          memRdValid = 1'b0;
  logic          resValid;
  logic [1:0]    resCode;
  logic [AW-1:0] resTableAddr;
  logic [EW-1:0] resErrCode;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  swint_redirect #(.ADDR_W(AW), .ERR_W(EW)) u_swint_redirect (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqVector(reqVector), .reqIsHw(reqIsHw), .v86Mode(v86Mode),
    .extEnable(extEnable), .ioPriv(ioPriv), .permBase(permBase),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memRdValid(memRdValid), .resValid(resValid), .resCode(resCode),
    .resTableAddr(resTableAddr), .resErrCode(resErrCode)
  );

  typedef struct packed {
    logic [7:0]  vec;
    logic        hw;
    logic        v86;
    logic        ext;
    logic [1:0]  iopl;
    logic [31:0] base;
    logic [7:0]  data;
    logic [3:0]  lat;
    logic [1:0]  code;
  } vecEntry_t;

  localparam int NV = 12;
  localparam vecEntry_t VECS [NV] = '{
    '{8'h21, 1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_1000, 8'h00, 4'd0, 2'b01},
    '{8'h21, 1'b0, 1'b1, 1'b1, 2'd3, 32'h0000_1000, 8'h02, 4'd2, 2'b10},
    '{8'h21, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0000_1000, 8'h02, 4'd1, 2'b11},
    '{8'hFF, 1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_0088, 8'h7F, 4'd3, 2'b01},
    '{8'hFF, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0000_0088, 8'h80, 4'd0, 2'b11},
    '{8'h00, 1'b0, 1'b1, 1'b1, 2'd0, 32'h0000_2000, 8'hFE, 4'd1, 2'b01},
    '{8'h00, 1'b0, 1'b1, 1'b1, 2'd3, 32'h0000_2000, 8'h01, 4'd0, 2'b10},
    '{8'h08, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0000_2000, 8'h00, 4'd0, 2'b10},
    '{8'h30, 1'b0, 1'b1, 1'b0, 2'd3, 32'h0000_2000, 8'h00, 4'd0, 2'b10},
    '{8'h30, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_2000, 8'h00, 4'd0, 2'b11},
    '{8'h30, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000_2000, 8'h00, 4'd0, 2'b10},
    '{8'h8D, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0000_3000, 8'hDF, 4'd5, 2'b01}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] bmAddr(input logic [AW-1:0] base, input logic [7:0] v);
    return base - 32'd32 + {27'd0, v[7:3]};
  endfunction

  task automatic drive(input vecEntry_t e);
    reqVector = e.vec; reqIsHw = e.hw; v86Mode = e.v86;
    extEnable = e.ext; ioPriv = e.iopl; permBase = e.base;
    reqValid = 1'b1;
  endtask

  task automatic checkResult(input string req, input vecEntry_t e);
    chk({req, " valid"}, 64'(resValid), 64'd1);
    chk({req, " code"}, 64'(resCode), 64'(e.code));
    chk({req, " tableAddr"}, 64'(resTableAddr),
        (e.code == 2'b01) ? 64'({e.vec, 2'b00}) : 64'd0);
    if (e.code == 2'b11) chk("R5 errCode", 64'(resErrCode), 64'd0);
  endtask

  task automatic runEntry(input vecEntry_t e, input string req);
    logic lookup;
    lookup = e.v86 && e.ext && !e.hw;
    drive(e);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    if (lookup) begin
      chk("R2 rdEn", 64'(memRdEn), 64'd1);
      chk("R2 rdAddr", 64'(memRdAddr), 64'(bmAddr(e.base, e.vec)));
      for (int i = 0; i < int'(e.lat); i++) begin
        @(negedge clk);
        chk("R2 held", 64'({memRdEn, resValid}), 64'b10);
        chk("R2 addr stable", 64'(memRdAddr), 64'(bmAddr(e.base, e.vec)));
      end
      memRdData = e.data; memRdValid = 1'b1;
      @(negedge clk);
      memRdValid = 1'b0;
    end else begin
      chk({req, " no read"}, 64'(memRdEn), 64'd0);
    end
    checkResult(req, e);
    @(negedge clk);
    chk("R9 pulse ends", 64'(resValid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    vecEntry_t e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 resValid", 64'(resValid), 64'd0);
    chk("R1 memRdEn", 64'(memRdEn), 64'd0);
    chk("R1 reqReady", 64'(reqReady), 64'd1);

    for (int k = 0; k < NV; k++) begin
      string tag;
      e = VECS[k];
      if (e.hw) tag = "R6";
      else if (!e.v86) tag = "R8";
      else if (!e.ext) tag = "R7";
      else if (e.code == 2'b01) tag = "R3";
      else if (e.code == 2'b10) tag = "R4";
      else tag = "R5";
      runEntry(e, tag);
    end

    // R9: busy unit ignores a second request
    e = VECS[0];
    drive(e);
    @(posedge clk); @(negedge clk);
    chk("R9 not ready", 64'(reqReady), 64'd0);
    reqVector = 8'h08; reqIsHw = 1'b1; permBase = 32'h0000_9000;
    @(negedge clk);
    chk("R9 ignored no result", 64'(resValid), 64'd0);
    chk("R9 addr kept", 64'(memRdAddr), 64'(bmAddr(32'h0000_1000, 8'h21)));
    reqValid = 1'b0;
    memRdData = 8'h00; memRdValid = 1'b1;
    @(negedge clk);
    memRdValid = 1'b0;
    checkResult("R9 first request", e);
    @(negedge clk);
    chk("R9 no extra result", 64'({resValid, memRdEn}), 64'd0);

    // R10: request accepted during a result strobe
    e = VECS[7];
    drive(e);
    @(posedge clk); @(negedge clk);
    chk("R10 strobe", 64'({resValid, reqReady}), 64'b11);
    e = VECS[11];
    drive(e);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R10 strobe dropped", 64'(resValid), 64'd0);
    chk("R10 new read", 64'(memRdEn), 64'd1);
    chk("R10 new addr", 64'(memRdAddr), 64'(bmAddr(e.base, e.vec)));
    memRdData = e.data; memRdValid = 1'b1;
    @(negedge clk);
    memRdValid = 1'b0;
    checkResult("R10 second result", e);
    @(negedge clk);

    // R11: reset in the middle of a lookup
    e = VECS[1];
    drive(e);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 idle", 64'({memRdEn, reqReady, resValid}), 64'b010);
    memRdData = 8'hFF; memRdValid = 1'b1;
    @(negedge clk);
    memRdValid = 1'b0;
    chk("R11 no result", 64'(resValid), 64'd0);

    // R12: stray read data while idle
    memRdValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    memRdValid = 1'b0;
    chk("R12 stray ignored", 64'({resValid, memRdEn, reqReady}), 64'b001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule